// File: doc/BRIEF.md
# System Control Register File with Interval Timer

This block holds the 32 system control registers that a 64-bit MIPS-style core reads and writes with its coprocessor move instructions. A combinational read port serves the move-from forms. The 32-bit form returns the masked value sign-extended from bit 31, and the 64-bit form returns the full masked value. A write port serves the move-to forms. The 32-bit form stores the sign-extended low word, and the 64-bit form stores all 64 bits. Each register applies a fixed readback mask, so bits that are not implemented always read as zero.

The block also keeps a cycle counter. The visible Count is the internal counter shifted right by one, so it advances once every two clocks. When the visible Count equals Compare, the timer pending flag (Cause bit 15) is raised. A write to Compare clears that flag. An exception-return request picks the resume address. It uses ErrorEPC (register 30) when Status bit 2 is set, and otherwise EPC (register 14). It then clears the matching Status bit and, one clock later, presents the address together with a one-cycle strobe.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, Status (register 12) reads 0x0000000000400004 (bit 2 and bit 22 set), Cause (13), Count (9) and Compare (11) read zero, and register 15 reads the PRID_VAL parameter (default 0x0B00).
- R2: A 64-bit read returns the stored value ANDed with the register's mask. Some masks: register 0 0x8000003F, 1 0x3F, 2 and 3 0x7FFFFFFF, 5 0x01FFE000, 10 0xC00000FFFFFFE0FF, 13 0xB000FFFF, 15 0xFFFF, 18 0xFFFFFFFB, 28 0x0FFFFFC0.
- R3: Registers 26, 27 and 29 always read zero, whatever was written to them.
- R4: A 32-bit read returns the low 32 bits of the masked value, sign-extended from bit 31.
- R5: A 64-bit write stores all 64 bits. A 32-bit write stores the low 32 bits sign-extended from bit 31.
- R6: Count reads as the internal counter shifted right by one and zero-extended, so it advances every two clocks. A write to Count sets the visible value to the written low 32 bits from the next clock on.
- R7: When the visible Count equals Compare's low 32 bits, Cause bit 15 is set on the next clock edge. It stays set until Compare is written.
- R8: A write to Compare in either form clears Cause bit 15, and this wins over a match in the same cycle. A write to Cause never changes bit 15.
- R9: An exception return with Status bit 2 set clears that bit and leaves bit 1 alone. One clock later, eret_taken_o pulses for one cycle and eret_pc_o holds ErrorEPC.
- R10: An exception return with Status bit 2 clear clears Status bit 1. One clock later, eret_pc_o holds EPC.
- R11: A read of a register in the same cycle as a write to it returns the old value. The new value is visible after the clock edge.
- R12: A write to Status in the same cycle as an exception return is dropped. Status only has the return's bit cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_i | input | 5 | Register number to read |
| rd_dword_i | input | 1 | 1: 64-bit read form, 0: 32-bit sign-extended form |
| rd_data_o | output | 64 | Masked read data |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 5 | Register number to write |
| wr_dword_i | input | 1 | 1: 64-bit write form, 0: 32-bit sign-extended form |
| wr_data_i | input | 64 | Write data |
| eret_i | input | 1 | Exception-return request |
| eret_pc_o | output | 64 | Resume address, valid with the strobe |
| eret_taken_o | output | 1 | One-cycle strobe, one clock after eret_i |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a Compare write and a Count match. The bench loads Compare, then loads Count with the same value. In the very cycle the visible Count first equals Compare, it writes Compare again. It then expects bit 15 to stay clear over that edge and to rise one edge later, when the match still holds and no write is pending. The second pair is a Status write and an exception return. The bench issues both together and expects Status to have only the return's bit cleared, so the written value is lost.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW          = 64;
  localparam int IDX_COUNT   = 9;
  localparam int IDX_COMPARE = 11;
  localparam int IDX_STATUS  = 12;
  localparam int IDX_CAUSE   = 13;
  localparam int IDX_EPC     = 14;
  localparam int IDX_PRID    = 15;
  localparam int IDX_ERREPC  = 30;
  localparam int ST_EXL      = 1;
  localparam int ST_ERL      = 2;
  localparam int CA_TIMER    = 15;

  // readback mask, indexed by register number
  function automatic logic [DW-1:0] reg_mask(input int idx);
    case (idx)
      0:              return 64'h0000_0000_8000_003F;
      1, 7:           return 64'h0000_0000_0000_003F;
      2, 3, 16:       return 64'h0000_0000_7FFF_FFFF;
      4:              return 64'hFFFF_FFFF_FFFF_FFF0;
      5:              return 64'h0000_0000_01FF_E000;
      9, 11, 12, 17:  return 64'h0000_0000_FFFF_FFFF;
      10:             return 64'hC000_00FF_FFFF_E0FF;
      13:             return 64'h0000_0000_B000_FFFF;
      15:             return 64'h0000_0000_0000_FFFF;
      18:             return 64'h0000_0000_FFFF_FFFB;
      19:             return 64'h0000_0000_0000_000F;
      26, 27, 29:     return 64'h0;
      28:             return 64'h0000_0000_0FFF_FFC0;
      default:        return '1;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_timer.sv
module sysctl_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] compare_o,
  output logic             pending_o
);
  logic [CNT_W:0]   cnt_q;  // one extra low bit: half-rate visible count
  logic [CNT_W-1:0] cmp_q;
  logic             pend_q;
  logic             match;

  assign count_o   = cnt_q[CNT_W:1];
  assign compare_o = cmp_q;
  assign pending_o = pend_q;
  assign match     = (cnt_q[CNT_W:1] == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cnt_wr_i) cnt_q <= {cnt_wdata_i, 1'b0};
      else          cnt_q <= cnt_q + 1'b1;
      if (cmp_wr_i) cmp_q <= cmp_wdata_i;
      if (cmp_wr_i)   pend_q <= 1'b0;
      else if (match) pend_q <= 1'b1;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_i |=> cnt_q == $past(cnt_q) + 1'b1); // R6
  AST_MATCH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == compare_o && !cmp_wr_i) |=> pending_o); // R7
  AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !cmp_wr_i) |=> pending_o); // R7
  AST_CMP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_wr_i |=> !pending_o); // R8
endmodule

// File: rtl/sysctl_eret.sv
module sysctl_eret
  import sysctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eret_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] epc_i,
  input  logic [DW-1:0] errepc_i,
  output logic          clr_erl_o,
  output logic          clr_exl_o,
  output logic [DW-1:0] pc_o,
  output logic          taken_o
);
  logic          erl;
  logic [DW-1:0] pc_q;
  logic          taken_q;

  assign erl       = status_i[ST_ERL];
  assign clr_erl_o = eret_i & erl;
  assign clr_exl_o = eret_i & ~erl;
  assign pc_o      = pc_q;
  assign taken_o   = taken_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= eret_i;
      if (eret_i) pc_q <= erl ? errepc_i : epc_i;
    end
  end

  AST_ERET_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eret_i |=> taken_o); // R9
  AST_ERET_ERRPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && status_i[ST_ERL]) |=> pc_o == $past(errepc_i)); // R9
  AST_ERET_EPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !status_i[ST_ERL]) |=> pc_o == $past(epc_i)); // R10
endmodule

// File: rtl/sysctl_read.sv
module sysctl_read
  import sysctl_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW = $clog2(NREGS)
) (
  input  logic [DW-1:0] view_i [NREGS],
  input  logic [AW-1:0] addr_i,
  input  logic          dword_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] masked [NREGS];
  logic [DW-1:0] sel;

  for (genvar i = 0; i < NREGS; i++) begin : g_mask
    assign masked[i] = view_i[i] & reg_mask(i);
  end

  assign sel    = masked[addr_i];
  assign data_o = dword_i ? sel : {{(DW-32){sel[31]}}, sel[31:0]};

  always_comb begin
    if (addr_i == AW'(26) || addr_i == AW'(27) || addr_i == AW'(29))
      AST_ZERO_REGS: assert (data_o == '0); // R3
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int          NREGS      = 32,
  parameter int          CNT_W      = 32,
  parameter logic [15:0] PRID_VAL   = 16'h0B00,
  parameter logic [31:0] STATUS_RST = 32'h0040_0004,
  localparam int AW = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          rd_dword_i,
  output logic [63:0]   rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_dword_i,
  input  logic [63:0]   wr_data_i,
  input  logic          eret_i,
  output logic [63:0]   eret_pc_o,
  output logic          eret_taken_o
);
  logic [DW-1:0]    wval;
  logic [DW-1:0]    view [NREGS];
  logic [CNT_W-1:0] count, compare;
  logic             pending;
  logic             clr_erl, clr_exl;
  logic [DW-1:0]    status_q;

  assign wval = wr_dword_i ? wr_data_i : {{(DW-32){wr_data_i[31]}}, wr_data_i[31:0]};

  function automatic logic hit(input logic [AW-1:0] a, input int idx);
    return wr_en_i && (a == AW'(idx));
  endfunction

  sysctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt_wr_i    (hit(wr_addr_i, IDX_COUNT)),
    .cnt_wdata_i (wval[CNT_W-1:0]),
    .cmp_wr_i    (hit(wr_addr_i, IDX_COMPARE)),
    .cmp_wdata_i (wval[CNT_W-1:0]),
    .count_o     (count),
    .compare_o   (compare),
    .pending_o   (pending)
  );

  sysctl_eret u_eret (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eret_i    (eret_i),
    .status_i  (status_q),
    .epc_i     (view[IDX_EPC]),
    .errepc_i  (view[IDX_ERREPC]),
    .clr_erl_o (clr_erl),
    .clr_exl_o (clr_exl),
    .pc_o      (eret_pc_o),
    .taken_o   (eret_taken_o)
  );

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == IDX_COUNT) begin : g_cnt
      assign view[i] = DW'(count);
    end else if (i == IDX_COMPARE) begin : g_cmp
      assign view[i] = DW'(compare);
    end else if (i == IDX_STATUS) begin : g_st
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               status_q <= DW'(STATUS_RST);
        else if (clr_erl)          status_q[ST_ERL] <= 1'b0;
        else if (clr_exl)          status_q[ST_EXL] <= 1'b0;
        else if (hit(wr_addr_i, i)) status_q <= wval;
      end
      assign view[i] = status_q;
    end else if (i == IDX_CAUSE) begin : g_cause
      logic [DW-1:0] cause_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                cause_q <= '0;
        else if (hit(wr_addr_i, i)) cause_q <= wval;
      end
      // timer bit is owned by the timer, not by software
      always_comb begin
        view[i] = cause_q;
        view[i][CA_TIMER] = pending;
      end
    end else begin : g_gen
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                q <= (i == IDX_PRID) ? DW'(PRID_VAL) : '0;
        else if (hit(wr_addr_i, i)) q <= wval;
      end
      assign view[i] = q;
    end
  end

  sysctl_read #(.NREGS(NREGS)) u_read (
    .view_i  (view),
    .addr_i  (rd_addr_i),
    .dword_i (rd_dword_i),
    .data_o  (rd_data_o)
  );

  AST_ERL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && status_q[ST_ERL]) |=> !status_q[ST_ERL]); // R9
  AST_EXL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !status_q[ST_ERL]) |=> !status_q[ST_EXL]); // R10
  AST_STATUS_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && wr_en_i && wr_addr_i == AW'(IDX_STATUS))
      |=> status_q[DW-1:3] == $past(status_q[DW-1:3])); // R12
endmodule

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_addr_i = '0;
  logic        rd_dword_i = 1'b1;
  logic [63:0] rd_data_o;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic        wr_dword_i = 1'b1;
  logic [63:0] wr_data_i = '0;
  logic        eret_i = 1'b0;
  logic [63:0] eret_pc_o;
  logic        eret_taken_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sysctl_regfile u_dut (
    .clk_i (clk), .rst_ni (rst_ni),
    .rd_addr_i (rd_addr_i), .rd_dword_i (rd_dword_i), .rd_data_o (rd_data_o),
    .wr_en_i (wr_en_i), .wr_addr_i (wr_addr_i), .wr_dword_i (wr_dword_i),
    .wr_data_i (wr_data_i), .eret_i (eret_i),
    .eret_pc_o (eret_pc_o), .eret_taken_o (eret_taken_o)
  );

  // {addr, write dword, write data, read dword, expected}
  function automatic logic [134:0] mkv(logic [4:0] a, logic wd, logic [63:0] d,
                                       logic rdw, logic [63:0] e);
    return {a, wd, d, rdw, e};
  endfunction

  localparam logic [63:0] ONES = '1;
  localparam logic [134:0] VEC [NV] = '{
    mkv(5'd0,  1'b1, ONES, 1'b1, 64'h0000_0000_8000_003F),          // R2
    mkv(5'd0,  1'b1, ONES, 1'b0, 64'hFFFF_FFFF_8000_003F),          // R4
    mkv(5'd1,  1'b0, 64'hFFFF_FFFF, 1'b1, 64'h3F),                  // R2 R5
    mkv(5'd2,  1'b1, ONES, 1'b1, 64'h7FFF_FFFF),                    // R2
    mkv(5'd5,  1'b1, ONES, 1'b1, 64'h01FF_E000),                    // R2
    mkv(5'd15, 1'b1, ONES, 1'b1, 64'hFFFF),                         // R2
    mkv(5'd26, 1'b1, ONES, 1'b1, 64'h0),                            // R3
    mkv(5'd27, 1'b1, ONES, 1'b0, 64'h0),                            // R3
    mkv(5'd29, 1'b1, ONES, 1'b1, 64'h0),                            // R3
    mkv(5'd14, 1'b0, 64'h8000_1234, 1'b1, 64'hFFFF_FFFF_8000_1234), // R5
    mkv(5'd10, 1'b1, ONES, 1'b1, 64'hC000_00FF_FFFF_E0FF),          // R2
    mkv(5'd13, 1'b1, ONES, 1'b1, 64'hB000_7FFF),                    // R8
    mkv(5'd18, 1'b1, 64'h1234_567F, 1'b0, 64'h1234_567B),           // R2 R4
    mkv(5'd28, 1'b1, ONES, 1'b1, 64'h0FFF_FFC0),                    // R2
    mkv(5'd20, 1'b1, 64'h8000_0000_0000_0001, 1'b0, 64'h1),         // R4
    mkv(5'd14, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b1, 64'h0123_4567_89AB_CDEF) // R5
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, released at the next falling edge
  task automatic wr(input logic [4:0] a, input logic dw, input logic [63:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_dword_i = dw; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic dw, output logic [63:0] d);
    rd_addr_i = a; rd_dword_i = dw;
    #1 d = rd_data_o;
  endtask

  initial begin : watchdog
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [63:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1: checked before the first active edge
    rd(5'd12, 1'b1, v); chk("R1 status", v, 64'h0040_0004);
    rd(5'd13, 1'b1, v); chk("R1 cause", v, 64'h0);
    rd(5'd9,  1'b1, v); chk("R1 count", v, 64'h0);
    rd(5'd11, 1'b1, v); chk("R1 compare", v, 64'h0);
    rd(5'd15, 1'b1, v); chk("R1 prid", v, 64'h0B00);

    wr(5'd11, 1'b1, 64'hFFFF_FFF0);
    rd(5'd13, 1'b1, v); chk("R8 cmp write clears", {63'b0, v[15]}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][134:130], VEC[i][129], VEC[i][128:65]);
      rd(VEC[i][134:130], VEC[i][64], v);
      chk($sformatf("R2-table vector %0d", i), v, VEC[i][63:0]);
    end

    // R6: count pacing
    wr(5'd9, 1'b0, 64'd100);
    for (int k = 0; k < 5; k++) begin
      rd(5'd9, 1'b1, v); chk("R6 count", v, 64'(100 + k / 2));
      @(negedge clk);
    end

    // R7: match raises and holds pending
    wr(5'd11, 1'b0, 64'd203);
    wr(5'd9, 1'b0, 64'd200);
    for (int k = 0; k < 12; k++) begin
      rd(5'd9, 1'b1, v);  chk("R6 count", v, 64'(200 + k / 2));
      rd(5'd13, 1'b1, v); chk("R7 pending", {63'b0, v[15]}, (k >= 7) ? 64'h1 : 64'h0);
      @(negedge clk);
    end

    // R8: 64-bit compare write clears pending
    wr(5'd11, 1'b1, 64'hFFFF_FFF0);
    rd(5'd13, 1'b1, v); chk("R8 clear", {63'b0, v[15]}, 64'h0);

    // R8: compare write in the match cycle wins
    wr(5'd11, 1'b0, 64'd300);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 5'd9; wr_dword_i = 1'b0; wr_data_i = 64'd300;
    @(negedge clk);
    wr_addr_i = 5'd11;
    rd(5'd9, 1'b1, v); chk("R6 count load", v, 64'd300);
    @(negedge clk);
    wr_en_i = 1'b0;
    rd(5'd13, 1'b1, v); chk("R8 priority", {63'b0, v[15]}, 64'h0);
    @(negedge clk);
    rd(5'd13, 1'b1, v); chk("R7 set after priority", {63'b0, v[15]}, 64'h1);

    // R11: same-cycle read returns old value
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 5'd14; wr_dword_i = 1'b1; wr_data_i = 64'h5555_AAAA_5555_AAAA;
    rd(5'd14, 1'b1, v); chk("R11 old", v, 64'h0123_4567_89AB_CDEF);
    @(negedge clk);
    wr_en_i = 1'b0;
    rd(5'd14, 1'b1, v); chk("R11 new", v, 64'h5555_AAAA_5555_AAAA);

    // R9 / R10: exception return
    wr(5'd30, 1'b1, 64'hFFFF_FFFF_BFC0_0000);
    wr(5'd14, 1'b1, 64'h0000_0000_8000_0180);
    wr(5'd12, 1'b1, 64'h0040_0006);
    @(negedge clk); eret_i = 1'b1;
    @(negedge clk); eret_i = 1'b0;
    chk("R9 strobe", {63'b0, eret_taken_o}, 64'h1);
    chk("R9 pc", eret_pc_o, 64'hFFFF_FFFF_BFC0_0000);
    rd(5'd12, 1'b1, v); chk("R9 status", v, 64'h0040_0002);
    @(negedge clk);
    chk("R9 strobe width", {63'b0, eret_taken_o}, 64'h0);
    eret_i = 1'b1;
    @(negedge clk); eret_i = 1'b0;
    chk("R10 pc", eret_pc_o, 64'h8000_0180);
    rd(5'd12, 1'b1, v); chk("R10 status", v, 64'h0040_0000);

    // R12: status write dropped under a return
    @(negedge clk);
    eret_i = 1'b1;
    wr_en_i = 1'b1; wr_addr_i = 5'd12; wr_dword_i = 1'b1; wr_data_i = 64'h0040_0007;
    @(negedge clk);
    eret_i = 1'b0; wr_en_i = 1'b0;
    rd(5'd12, 1'b1, v); chk("R12 status", v, 64'h0040_0000);
    chk("R12 pc", eret_pc_o, 64'h8000_0180);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule